// File: doc/BRIEF.md
# Frame Boundary Offset Meter

This block measures how far an external frame evaluation signal lags the chip's own frame boundary. The chip marks its boundary with a one-cycle frame pulse. The measurement is armed when a host-controlled start level goes high. The block then waits for the next frame pulse and counts whole clock cycles from it. It watches the evaluation input for its first active edge. The active edge is the falling edge in the default framing convention and the rising edge in the alternate convention.

The evaluation input is sampled on both clock edges, which gives the result half-cycle resolution. A dedicated result bit records whether the edge fell in the high or the low half of the clock. Once an edge is caught, the block sets a done bit and freezes the count and phase in a 16-bit result word. The host reads this word. Lowering the start level clears the result. A new measurement is accepted only after a frame pulse has passed while the start level was low.

Top module: `frame_align_meter`

## Requirements
- R1: After reset, `resultOut` is all zeros.
- R2: A rise of `startEval` arms a measurement, which begins at the next clock edge where `framePulse` is sampled high. Active edges on `evalIn` before that edge leave `resultOut` at zero.
- R3: The count field `resultOut[10:0]` equals k when the edge falls in clock cycle k. Cycle 0 starts at the rising clock edge where `framePulse` was sampled high.
- R4: `resultOut[11]` is 1 when the edge occurred while `clk` was high, and 0 when it occurred while `clk` was low.
- R5: With `gciMode`=0 only a falling edge of `evalIn` is measured. With `gciMode`=1 only a rising edge is measured. A transition in the other direction leaves `resultOut` unchanged.
- R6: The done bit `resultOut[12]` is set together with the captured count and phase, one clock edge after the edge cycle ends. While `startEval` stays high, later edges leave `resultOut` unchanged.
- R7: A fall of `startEval` clears all of `resultOut` at the next rising clock edge.
- R8: A rise of `startEval` is ignored unless `framePulse` was sampled high while `startEval` was low, at some edge after its previous fall. Reset counts as having met this condition.
- R9: `resultOut[15:13]` are always zero.
- R10: While a measurement runs without an edge, each new frame pulse restarts the count, so the result is relative to the most recent pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; both edges sample `evalIn` |
| rstN | input | 1 | Asynchronous reset, active low |
| framePulse | input | 1 | One-cycle internal frame boundary marker |
| gciMode | input | 1 | 0: measure falling edge, 1: measure rising edge |
| startEval | input | 1 | Host start level; rise arms, fall clears |
| evalIn | input | 1 | External frame evaluation signal |
| resultOut | output | 16 | {3'b000, done, phase, count[10:0]} |

## Verification
The embedded properties check several rules on every cycle. The reserved result bits stay zero. A fall of the start level empties the whole result on the next edge. The done bit only rises while the start level is high and only falls after the start level has dropped. A completed result does not move while the start level holds. An unqualified rise of the start level keeps the controller idle. Only the bench scenarios can show that the captured count and phase are correct. They sweep every edge cycle and both clock halves in both polarities. They also show that transitions in the other direction are ignored, that edges before the frame pulse are ignored, and that the count restarts on a second frame pulse.

// File: rtl/frame_meas_pkg.sv
package frame_meas_pkg;

  typedef enum logic [1:0] {
    MS_IDLE    = 2'd0,
    MS_ARMED   = 2'd1,
    MS_MEASURE = 2'd2,
    MS_DONE    = 2'd3
  } measState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch count and phase, set done
    logic clearRes;  // empty the result word
  } measStrobe_t;

endpackage

// File: rtl/frame_align_ctrl.sv
module frame_align_ctrl
  import frame_meas_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        framePulse,
  input  logic        startEval,
  input  logic        edgeSeen,
  output measStrobe_t strobes
);

  measState_t state, stateNext;
  logic startPrev;
  logic eligible;
  logic startRise, startFall;

  assign startRise = startEval && !startPrev;
  assign startFall = !startEval && startPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startPrev <= 1'b0;
      eligible  <= 1'b1;
      state     <= MS_IDLE;
    end else begin
      startPrev <= startEval;
      state     <= stateNext;
      // a quiet frame with start low re-qualifies the next rise
      if (startFall)
        eligible <= 1'b0;
      else if (framePulse && !startEval)
        eligible <= 1'b1;
    end
  end

  always_comb begin
    stateNext = state;
    if (startFall) begin
      stateNext = MS_IDLE;
    end else begin
      unique case (state)
        MS_IDLE:    if (startRise && eligible) stateNext = MS_ARMED;
        MS_ARMED:   if (framePulse)            stateNext = MS_MEASURE;
        MS_MEASURE: if (edgeSeen)              stateNext = MS_DONE;
        MS_DONE:    stateNext = MS_DONE;
        default:    stateNext = MS_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.clearRes = startFall;
    strobes.capture  = (state == MS_MEASURE) && edgeSeen && startEval;
  end

  a_r8_unqualified_rise: assert property (@(posedge clk) disable iff (!rstN)
    (state == MS_IDLE && startRise && !eligible) |=> (state == MS_IDLE));

  a_r7_strobe_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.capture, strobes.clearRes}));

endmodule

// File: rtl/frame_align_dp.sv
module frame_align_dp
  import frame_meas_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             framePulse,
  input  logic             gciMode,
  input  logic             evalIn,
  input  measStrobe_t      strobes,
  output logic             edgeSeen,
  output logic [RES_W-1:0] resultOut
);

  localparam int RSV_W = RES_W - CNT_W - 2;

  logic             curNorm;   // active edge normalised to a rise
  logic             negNorm;   // sampled at falling clock edge
  logic             prevNorm;  // sampled at previous rising edge
  logic             edgeHigh, edgeLow;
  logic [CNT_W-1:0] cycleCnt;
  logic [CNT_W-1:0] capCnt;
  logic             capPhase;
  logic             capDone;

  assign curNorm = evalIn ^ !gciMode;

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) negNorm <= 1'b0;
    else       negNorm <= curNorm;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevNorm <= 1'b0;
      cycleCnt <= '0;
    end else begin
      prevNorm <= curNorm;
      cycleCnt <= framePulse ? '0 : cycleCnt + 1'b1;
    end
  end

  // high half seen first by the falling-edge flop, low half by this edge
  assign edgeHigh = !prevNorm && negNorm;
  assign edgeLow  = !prevNorm && !negNorm && curNorm;
  assign edgeSeen = edgeHigh || edgeLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capCnt   <= '0;
      capPhase <= 1'b0;
      capDone  <= 1'b0;
    end else if (strobes.clearRes) begin
      capCnt   <= '0;
      capPhase <= 1'b0;
      capDone  <= 1'b0;
    end else if (strobes.capture) begin
      capCnt   <= cycleCnt;
      capPhase <= edgeHigh;
      capDone  <= 1'b1;
    end
  end

  assign resultOut = {{RSV_W{1'b0}}, capDone, capPhase, capCnt};

endmodule

// File: rtl/frame_align_meter.sv
module frame_align_meter
  import frame_meas_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             framePulse,
  input  logic             gciMode,
  input  logic             startEval,
  input  logic             evalIn,
  output logic [RES_W-1:0] resultOut
);

  localparam int DONE_BIT = CNT_W + 1;

  measStrobe_t strobes;
  logic        edgeSeen;

  frame_align_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .framePulse (framePulse),
    .startEval  (startEval),
    .edgeSeen   (edgeSeen),
    .strobes    (strobes)
  );

  frame_align_dp #(.CNT_W(CNT_W), .RES_W(RES_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .framePulse (framePulse),
    .gciMode    (gciMode),
    .evalIn     (evalIn),
    .strobes    (strobes),
    .edgeSeen   (edgeSeen),
    .resultOut  (resultOut)
  );

  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    resultOut[RES_W-1:DONE_BIT+1] == '0);

  a_r7_zero_after_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(startEval) |=> (resultOut == '0));

  a_r7_done_drops_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(resultOut[DONE_BIT]) |-> !$past(startEval));

  a_r6_hold_result: assert property (@(posedge clk) disable iff (!rstN)
    (resultOut[DONE_BIT] && startEval) |=> $stable(resultOut));

  a_r2_done_needs_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resultOut[DONE_BIT]) |-> $past(startEval));

endmodule

// File: tb/sim_frame_align_meter.sv
module sim_frame_align_meter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        framePulse = 1'b0;
  logic        gciMode = 1'b0;
  logic        startEval = 1'b0;
  logic        evalIn = 1'b1;
  logic [15:0] resultOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  frame_align_meter u0 (
    .clk(clk), .rstN(rstN), .framePulse(framePulse), .gciMode(gciMode),
    .startEval(startEval), .evalIn(evalIn), .resultOut(resultOut)
  );

  function automatic logic [15:0] expWord(input bit done, input bit ph, input int k);
    return {3'b000, done, ph, k[10:0]};
  endfunction

  task automatic check(input logic [15:0] exp, input string req);
    total++;
    if (resultOut !== exp) begin
      bad++;
      $display("FAIL %s: result=%h expected=%h", req, resultOut, exp);
    end
  endtask

  task automatic setStart(input bit v);
    @(negedge clk); #1 startEval = v;
  endtask

  // returns 2 ns after the rising edge that samples the pulse
  task automatic pulseFrame();
    @(negedge clk); #1 framePulse = 1'b1;
    @(posedge clk); #2 framePulse = 1'b0;
  endtask

  // wait n rising edges, then drive evalIn in the chosen clock half
  task automatic edgeAt(input int n, input bit highHalf, input bit v);
    repeat (n) @(posedge clk);
    if (highHalf) #5 evalIn = v;
    else begin @(negedge clk); #5 evalIn = v; end
  endtask

  task automatic settle();
    @(posedge clk); #5;
  endtask

  task automatic measureRun(input bit gci, input int k, input bit half);
    bit act = gci;
    setStart(1'b0);
    gciMode = gci;
    evalIn  = !act;
    pulseFrame();
    setStart(1'b1);
    pulseFrame();
    edgeAt(k, half, act);
    settle();
    check(expWord(1'b1, half, k), "R3/R4/R5/R6/R9 sweep");
    setStart(1'b0);
    settle();
    check(16'h0000, "R7 clear on fall");
    evalIn = !act;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5;
    check(16'h0000, "R1 reset value");
    @(negedge clk); rstN = 1'b1;
    settle();
    check(16'h0000, "R1 after release");

    // R3 R4 R5 sweep: every cycle offset, both halves, both polarities
    for (int g = 0; g < 2; g++)
      for (int h = 0; h < 2; h++)
        for (int k = 0; k < 48; k++)
          measureRun(g[0], k, h[0]);

    // R5: opposite direction ignored (falling-edge mode)
    setStart(1'b0); gciMode = 1'b0; evalIn = 1'b0;
    pulseFrame(); setStart(1'b1); pulseFrame();
    edgeAt(3, 1'b0, 1'b1);
    settle();
    check(16'h0000, "R5 rising edge ignored in falling mode");
    edgeAt(3, 1'b1, 1'b0);
    settle();
    check(expWord(1'b1, 1'b1, 7), "R5 falling edge measured");

    // R2: edges before the frame pulse are ignored
    setStart(1'b0); evalIn = 1'b1;
    pulseFrame(); setStart(1'b1);
    edgeAt(2, 1'b0, 1'b0);
    settle();
    check(16'h0000, "R2 edge while armed ignored");
    edgeAt(1, 1'b0, 1'b1);
    pulseFrame();
    edgeAt(5, 1'b0, 1'b0);
    settle();
    check(expWord(1'b1, 1'b0, 5), "R2 measurement after pulse");

    // R6: later edges do not disturb a finished result
    edgeAt(1, 1'b0, 1'b1);
    edgeAt(2, 1'b1, 1'b0);
    settle();
    check(expWord(1'b1, 1'b0, 5), "R6 result held");

    // R8: rise without an intervening quiet frame is ignored
    setStart(1'b0);
    setStart(1'b1);
    pulseFrame();
    edgeAt(1, 1'b0, 1'b1);
    edgeAt(2, 1'b0, 1'b0);
    settle();
    check(16'h0000, "R8 unqualified rise ignored");
    setStart(1'b0); evalIn = 1'b1;
    pulseFrame(); setStart(1'b1); pulseFrame();
    edgeAt(6, 1'b1, 1'b0);
    settle();
    check(expWord(1'b1, 1'b1, 6), "R8 qualified rise measures");

    // R10: no edge in first frame, count restarts on next pulse
    setStart(1'b0); gciMode = 1'b1; evalIn = 1'b0;
    pulseFrame(); setStart(1'b1); pulseFrame();
    repeat (10) @(posedge clk);
    #2;
    check(16'h0000, "R10 still running");
    pulseFrame();
    edgeAt(4, 1'b1, 1'b1);
    settle();
    check(expWord(1'b1, 1'b1, 4), "R10 count from latest pulse");
    setStart(1'b0);
    settle();
    check(16'h0000, "R7 final clear");

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule